// File: doc/BRIEF.md
# FMA Special Operand Resolver

This block sits at the front of a double-precision fused multiply-add / multiply-subtract unit that computes `z + x*y`, or `z - x*y` when the negate-product input is set. It sorts each of the three 64-bit IEEE-754 operands into zero, finite non-zero (normal or subnormal), infinity, quiet NaN or signalling NaN. From those classes it decides, in purely combinational logic, whether the final answer is already fixed.

When the answer is fixed, the block raises a valid flag and presents the 64-bit result together with the invalid-operation flag. When both product operands are finite non-zero and `z` is finite, it instead tells the arithmetic datapath to carry on. The sign of an exactly cancelling zero sum depends on the rounding mode, so a round-toward-minus-infinity indicator is an input.

Top module: `fma_special_resolver`

## Requirements
- R1: If any operand is a signalling NaN (exponent all ones, fraction non-zero, fraction bit 51 clear), the first such operand in the order z, x, y is returned with fraction bit 51 set, and invalid-operation is raised.
- R2: With no signalling NaN present, the first quiet NaN (fraction bit 51 set) in the order z, x, y is returned bit for bit, and invalid-operation stays low.
- R3: An infinity multiplied by a zero, in either operand position, returns 0x7FF8000000000000 and raises invalid-operation.
- R4: The effective product sign is bit 63 of x XOR bit 63 of y, inverted when negate-product is set. An infinite product combined with an infinite z of the other sign returns 0x7FF8000000000000 and raises invalid-operation.
- R5: Any other infinite product returns an infinity (exponent all ones, fraction zero) with the effective product sign.
- R6: A finite non-zero product with an infinite z returns z.
- R7: A zero product with a zero z returns z when z's sign equals the effective product sign. Otherwise it returns a zero whose sign bit equals the round-toward-minus-infinity input.
- R8: A zero product with a finite non-zero z returns z unchanged.
- R9: A finite non-zero product with a finite z, subnormals included, gives valid low, continue high, invalid low and a zero result.
- R10: Continue is always the complement of valid. Invalid-operation is only ever raised with a valid quiet NaN result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 64 | Addend |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Negate the product (multiply-subtract) |
| rnd_down | input | 1 | Rounding toward minus infinity is active |
| spec_valid | output | 1 | Result is a special value |
| spec_result | output | 64 | Special result, zero when not valid |
| invalid_op | output | 1 | Invalid-operation exception |
| to_datapath | output | 1 | Finite arithmetic must compute the result |

## Verification
The block holds no state, so a wrong class decision or priority choice shows at the ports within the same evaluation as the inputs that trigger it. A misclassified operand shows up in one of two ways: the wrong NaN is chosen, or valid and continue swap. A sign error shows as a flipped bit 63 on infinities or exact zeros. The directed scenarios therefore pair operands that differ only in one sign, in one class or in NaN position. Each output is sampled a fixed delay after the operands change.

// File: rtl/fsr_pkg.sv
// Shared types for the FMA special operand resolver.
package fsr_pkg;
    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_FIN  = 3'd1,
        CL_INF  = 3'd2,
        CL_QNAN = 3'd3,
        CL_SNAN = 3'd4
    } opclass_e;
endpackage

// File: rtl/fsr_classify.sv
// Sorts one IEEE-754 operand into a class and extracts its sign.
// Assumes the standard sign|exponent|fraction layout; subnormals are finite.
module fsr_classify #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]     val,
    output fsr_pkg::opclass_e cls,
    output logic             sgn
);
    import fsr_pkg::*;

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign ex  = val[W-2 -: EXP_W];
    assign fr  = val[FRAC_W-1:0];
    assign sgn = val[W-1];

    // Decide the class from exponent and fraction fields.
    always_comb begin
        if (&ex) begin
            if (fr == '0)           cls = CL_INF;
            else if (fr[FRAC_W-1])  cls = CL_QNAN;
            else                    cls = CL_SNAN;
        end else if (ex == '0 && fr == '0) begin
            cls = CL_ZERO;
        end else begin
            cls = CL_FIN;
        end
    end
endmodule

// File: rtl/fsr_nan_pick.sv
// Selects the NaN to return: signalling before quiet, lowest index first.
// Index 0 is z, 1 is x, 2 is y. A signalling pick is returned quieted.
module fsr_nan_pick #(
    parameter int W      = 64,
    parameter int FRAC_W = 52,
    parameter int N      = 3
) (
    input  fsr_pkg::opclass_e cls [N],
    input  logic [W-1:0]      ops [N],
    output logic              hit,
    output logic              sig,
    output logic [W-1:0]      nan_out
);
    import fsr_pkg::*;

    logic           s_any, q_any;
    logic [W-1:0]   s_val, q_val;

    // Scan from the last operand down so the first in order wins.
    always_comb begin
        s_any = 1'b0;
        q_any = 1'b0;
        s_val = '0;
        q_val = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (cls[i] == CL_SNAN) begin
                s_any = 1'b1;
                s_val = ops[i];
            end
            if (cls[i] == CL_QNAN) begin
                q_any = 1'b1;
                q_val = ops[i];
            end
        end
    end

    // Merge the two candidates; quiet the signalling one.
    always_comb begin
        hit     = s_any | q_any;
        sig     = s_any;
        nan_out = '0;
        if (s_any) begin
            nan_out = s_val;
            nan_out[FRAC_W-1] = 1'b1;
        end else if (q_any) begin
            nan_out = q_val;
        end
    end
endmodule

// File: rtl/fsr_inf_zero.sv
// Resolves infinity and zero combinations when no operand is a NaN.
// Assumes NaN inputs are overridden by the NaN picker above it.
module fsr_inf_zero #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  fsr_pkg::opclass_e cls_z,
    input  fsr_pkg::opclass_e cls_x,
    input  fsr_pkg::opclass_e cls_y,
    input  logic              zs,
    input  logic              xs,
    input  logic              ys,
    input  logic [W-1:0]      op_z,
    input  logic              neg_prod,
    input  logic              rnd_down,
    output logic              hit,
    output logic              inv,
    output logic [W-1:0]      res,
    output logic              go
);
    import fsr_pkg::*;

    localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic eff, p_inf, p_zero, z_inf, z_zero;

    assign eff    = xs ^ ys ^ neg_prod;
    assign p_inf  = (cls_x == CL_INF)  | (cls_y == CL_INF);
    assign p_zero = (cls_x == CL_ZERO) | (cls_y == CL_ZERO);
    assign z_inf  = (cls_z == CL_INF);
    assign z_zero = (cls_z == CL_ZERO);

    // Apply the ordered special-value rules.
    always_comb begin
        hit = 1'b1;
        inv = 1'b0;
        res = op_z;
        go  = 1'b0;
        if (p_inf && p_zero) begin
            inv = 1'b1;
            res = DEF_NAN;
        end else if (p_inf) begin
            if (z_inf && zs != eff) begin
                inv = 1'b1;
                res = DEF_NAN;
            end else begin
                res = {eff, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end else if (p_zero) begin
            if (z_zero && zs != eff)
                res = {rnd_down, {(W-1){1'b0}}};
        end else if (!z_inf) begin
            hit = 1'b0;
            res = '0;
            go  = 1'b1;
        end
    end
endmodule

// File: rtl/fma_special_resolver.sv
// Top of the special operand resolver for z +/- x*y.
// Classifies the three operands, picks NaNs by priority, otherwise
// resolves infinity/zero cases, and flags when finite arithmetic is needed.
module fma_special_resolver #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int NOPS  = 3
) (
    input  logic [W-1:0] op_z,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         neg_prod,
    input  logic         rnd_down,
    output logic         spec_valid,
    output logic [W-1:0] spec_result,
    output logic         invalid_op,
    output logic         to_datapath
);
    import fsr_pkg::*;

    logic [W-1:0] ops [NOPS];
    opclass_e     cls [NOPS];
    logic         sgn [NOPS];

    assign ops[0] = op_z;
    assign ops[1] = op_x;
    assign ops[2] = op_y;

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fsr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val(ops[g]), .cls(cls[g]), .sgn(sgn[g])
        );
    end

    logic         n_hit, n_sig;
    logic [W-1:0] n_val;

    fsr_nan_pick #(.W(W), .FRAC_W(FRAC_W), .N(NOPS)) u_nan (
        .cls(cls), .ops(ops), .hit(n_hit), .sig(n_sig), .nan_out(n_val)
    );

    logic         r_hit, r_inv, r_go;
    logic [W-1:0] r_res;

    fsr_inf_zero #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_iz (
        .cls_z(cls[0]), .cls_x(cls[1]), .cls_y(cls[2]),
        .zs(sgn[0]), .xs(sgn[1]), .ys(sgn[2]),
        .op_z(op_z), .neg_prod(neg_prod), .rnd_down(rnd_down),
        .hit(r_hit), .inv(r_inv), .res(r_res), .go(r_go)
    );

    // NaN handling takes precedence over every other rule.
    always_comb begin
        if (n_hit) begin
            spec_valid  = 1'b1;
            spec_result = n_val;
            invalid_op  = n_sig;
            to_datapath = 1'b0;
        end else begin
            spec_valid  = r_hit;
            spec_result = r_res;
            invalid_op  = r_inv;
            to_datapath = r_go;
        end
    end

    // Output consistency checks against the operand classes.
    always_comb begin
        AST_ONE_PATH: assert (spec_valid != to_datapath); // R10
        AST_INV_QNAN: assert (!invalid_op ||
            (spec_valid && (&spec_result[W-2 -: EXP_W]) && spec_result[FRAC_W-1])); // R10
        AST_NAN_WINS: assert (!n_hit || (spec_valid && spec_result[FRAC_W-1] && (&spec_result[W-2 -: EXP_W]))); // R1
        AST_GO_FINITE: assert (!to_datapath ||
            (cls[0] inside {CL_ZERO, CL_FIN} && cls[1] == CL_FIN && cls[2] == CL_FIN)); // R9
        AST_QNAN_QUIET: assert (!(n_hit && !n_sig) || !invalid_op); // R2
    end
endmodule

// File: tb/tb_fma_special_resolver.sv
module tb_fma_special_resolver;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [63:0] op_z, op_x, op_y;
    logic        neg_prod, rnd_down;
    logic        spec_valid, invalid_op, to_datapath;
    logic [63:0] spec_result;

    fma_special_resolver dut (
        .op_z(op_z), .op_x(op_x), .op_y(op_y),
        .neg_prod(neg_prod), .rnd_down(rnd_down),
        .spec_valid(spec_valid), .spec_result(spec_result),
        .invalid_op(invalid_op), .to_datapath(to_datapath)
    );

    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] THR  = 64'hC008_0000_0000_0000;
    localparam logic [63:0] SUB  = 64'h0000_0000_0000_0007;
    localparam logic [63:0] DEFN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNA  = 64'h7FF0_0000_0000_0011;
    localparam logic [63:0] SNB  = 64'hFFF0_0000_0000_0022;
    localparam logic [63:0] QNA  = 64'h7FF8_0000_0000_0033;
    localparam logic [63:0] QNB  = 64'hFFF8_0000_0000_0044;

    int total = 0;
    int bad = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive on the falling edge, sample one nanosecond later.
    task automatic apply(input logic [63:0] z, input logic [63:0] x, input logic [63:0] y,
                         input logic n, input logic rd);
        @(negedge clk);
        op_z = z; op_x = x; op_y = y; neg_prod = n; rnd_down = rd;
        #1;
    endtask

    task automatic expect_spec(input string tag, input logic [63:0] res, input logic inv);
        chk({tag, " valid"}, {63'd0, spec_valid}, 64'd1);
        chk({tag, " result"}, spec_result, res);
        chk({tag, " invalid"}, {63'd0, invalid_op}, {63'd0, inv});
        chk({tag, " continue"}, {63'd0, to_datapath}, 64'd0);
    endtask

    task automatic t_reset;
        apply(PZ, PZ, PZ, 1'b0, 1'b0);
        expect_spec("R7 reset zeros", PZ, 1'b0);
    endtask

    task automatic t_snan;
        apply(QNA, SNA, SNB, 1'b0, 1'b0);
        expect_spec("R1 x snan beats z qnan", SNA | 64'h0008_0000_0000_0000, 1'b1);
        apply(SNB, SNA, PZ, 1'b0, 1'b0);
        expect_spec("R1 z snan first", SNB | 64'h0008_0000_0000_0000, 1'b1);
        apply(ONE, QNA, SNB, 1'b1, 1'b0);
        expect_spec("R1 y snan beats x qnan", SNB | 64'h0008_0000_0000_0000, 1'b1);
    endtask

    task automatic t_qnan;
        apply(ONE, QNB, QNA, 1'b0, 1'b0);
        expect_spec("R2 x qnan first", QNB, 1'b0);
        apply(QNA, QNB, PINF, 1'b0, 1'b0);
        expect_spec("R2 z qnan first", QNA, 1'b0);
        apply(PINF, PZ, QNB, 1'b0, 1'b0);
        expect_spec("R2 y qnan over inf*0", QNB, 1'b0);
    endtask

    task automatic t_inf_zero;
        apply(ONE, PINF, PZ, 1'b0, 1'b0);
        expect_spec("R3 inf*0", DEFN, 1'b1);
        apply(NINF, NZ, NINF, 1'b1, 1'b0);
        expect_spec("R3 0*inf", DEFN, 1'b1);
    endtask

    task automatic t_inf_prod;
        apply(NINF, PINF, ONE, 1'b0, 1'b0);
        expect_spec("R4 opposite inf", DEFN, 1'b1);
        apply(PINF, PINF, ONE, 1'b1, 1'b0);
        expect_spec("R4 negated same sign", DEFN, 1'b1);
        apply(NINF, PINF, ONE, 1'b1, 1'b0);
        expect_spec("R5 negated matches z", NINF, 1'b0);
        apply(TWO, NINF, SUB, 1'b0, 1'b0);
        expect_spec("R5 neg inf product", NINF, 1'b0);
        apply(TWO, NINF, ONE, 1'b1, 1'b0);
        expect_spec("R5 negate flips", PINF, 1'b0);
        apply(PINF, NINF, NINF, 1'b0, 1'b0);
        expect_spec("R5 inf*inf", PINF, 1'b0);
    endtask

    task automatic t_z_inf;
        apply(NINF, ONE, TWO, 1'b0, 1'b0);
        expect_spec("R6 z neg inf", NINF, 1'b0);
        apply(PINF, SUB, THR, 1'b1, 1'b0);
        expect_spec("R6 z pos inf", PINF, 1'b0);
    endtask

    task automatic t_zero_sum;
        apply(PZ, PZ, ONE, 1'b0, 1'b1);
        expect_spec("R7 same sign keeps z", PZ, 1'b0);
        apply(NZ, PZ, ONE, 1'b0, 1'b0);
        expect_spec("R7 cancel rnd near", PZ, 1'b0);
        apply(NZ, PZ, ONE, 1'b0, 1'b1);
        expect_spec("R7 cancel rnd down", NZ, 1'b0);
        apply(NZ, PZ, TWO, 1'b1, 1'b0);
        expect_spec("R7 negated match", NZ, 1'b0);
        apply(PZ, NZ, NZ, 1'b1, 1'b1);
        expect_spec("R7 negated cancel down", NZ, 1'b0);
    endtask

    task automatic t_zero_prod;
        apply(THR, PZ, TWO, 1'b0, 1'b1);
        expect_spec("R8 z returned", THR, 1'b0);
        apply(SUB, NINF == 64'd0 ? ONE : ONE, NZ, 1'b1, 1'b0);
        expect_spec("R8 subnormal z", SUB, 1'b0);
    endtask

    task automatic t_datapath;
        apply(THR, ONE, TWO, 1'b0, 1'b0);
        chk("R9 valid", {63'd0, spec_valid}, 64'd0);
        chk("R9 continue", {63'd0, to_datapath}, 64'd1);
        chk("R9 invalid", {63'd0, invalid_op}, 64'd0);
        chk("R9 result", spec_result, 64'd0);
        apply(SUB, SUB, THR, 1'b1, 1'b1);
        chk("R10 subnormal continue", {63'd0, to_datapath}, 64'd1);
        chk("R10 subnormal valid", {63'd0, spec_valid}, 64'd0);
        apply(PZ, ONE, ONE, 1'b0, 1'b0);
        chk("R9 zero z continue", {63'd0, to_datapath}, 64'd1);
    endtask

    initial begin
        op_z = PZ; op_x = PZ; op_y = PZ; neg_prod = 1'b0; rnd_down = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_snan();
        t_qnan();
        t_inf_zero();
        t_inf_prod();
        t_z_inf();
        t_zero_sum();
        t_zero_prod();
        t_datapath();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule